// File: doc/BRIEF.md
# Indexed Fetch-and-Add Scatter Unit

This block carries out one vector scatter-accumulate into a single-ported scratchpad. When an operation is accepted, the unit latches a base address, a vector of per-lane indices, a vector of per-lane addends, a lane mask, a destination register number and a variant flag. It then walks the lanes one at a time, lowest lane first. For each active lane it reads the word at base plus that lane's index. On the next cycle it writes back the old word plus the lane's addend and keeps the old word for the return.

In the returning variant, the unit ends the walk with one return pulse. The pulse carries the saved pre-add words to the destination register through the same write path an ordinary load uses, with one write enable per lane. In the plain scatter-add variant, the memory is updated the same way but nothing is returned. Because lanes commit strictly in order, a later lane that hits the same address as an earlier lane sees the earlier lane's sum as its old value.

Top module: `scatter_fadd_unit`

## Requirements
- R1: During and right after reset, `busy`, `ret_valid`, `mem_rd_en`, `mem_wr_en` and `ret_lane_we` are all low.
- R2: `op_valid` seen while `busy` is low starts an operation, and `busy` is high from the next cycle until the walk completes. While `busy` is low the scratchpad port is not used.
- R3: The target address of lane i is `base_addr` plus `index_vec[i*AW +: AW]`, taken modulo 2^AW.
- R4: After an active lane commits, the word at its target address equals the old word plus `src_vec[i*DW +: DW]`, with 32-bit two's-complement wraparound.
- R5: In the returning variant, `ret_data[i*DW +: DW]` is the word read before the add, and `ret_dest` equals the latched `dest_reg`.
- R6: A lane whose `lane_mask[i]` is 0 causes no scratchpad read, no write and no return. Its `ret_lane_we[i]` is 0 and its `ret_data` lane is zero.
- R7: Lanes commit in ascending order. When two active lanes share an address, the higher lane's pre-add value is the lower lane's sum.
- R8: With `op_return` = 0, the memory is updated as in R3/R4 and `ret_valid` is never raised.
- R9: A returning operation raises `ret_valid` for exactly one cycle at the end of the walk, and `busy` falls on the following cycle.
- R10: `op_valid` while `busy` is high is ignored: it causes no memory access and no return.
- R11: An operation with every lane masked makes no scratchpad access. If it is a returning operation, it still gives one return pulse with all write enables low.
- R12: Every scratchpad read is followed on the next cycle by a write to the same address, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request, accepted when idle |
| op_return | input | 1 | 1 = return pre-add values, 0 = plain scatter-add |
| base_addr | input | AW | Base scratchpad word address |
| index_vec | input | LANES*AW | Per-lane index, lane i at bits i*AW |
| src_vec | input | LANES*DW | Per-lane addend, lane i at bits i*DW |
| lane_mask | input | LANES | Active lanes, bit i = lane i |
| dest_reg | input | RW | Destination vector register number |
| mem_rd_en | output | 1 | Scratchpad read strobe |
| mem_rd_addr | output | AW | Scratchpad read address |
| mem_rd_data | input | DW | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Scratchpad write strobe |
| mem_wr_addr | output | AW | Scratchpad write address |
| mem_wr_data | output | DW | Scratchpad write data |
| busy | output | 1 | Lane walk in progress |
| ret_valid | output | 1 | One-cycle return pulse |
| ret_dest | output | RW | Destination register for the return |
| ret_lane_we | output | LANES | Per-lane destination write enables |
| ret_data | output | LANES*DW | Pre-add values, lane i at bits i*DW |

## Verification
The assertions assume the scratchpad returns read data exactly one cycle after the strobe. They also assume no other agent writes the scratchpad while an operation is running, so read-then-write pairs and in-order commits can be judged from the port alone. The stimulus meets both conditions: a bench memory answers with a single registered read and is touched only by the unit. Requests are raised only at operation boundaries, except for one deliberate request during a walk, which R10 says must be ignored.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEEK  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } walk_state_e;
endpackage

// File: rtl/fadd_lane_walker.sv
module fadd_lane_walker
  import fadd_pkg::*;
#(
  parameter int LANES = 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LANES-1:0] mask_q,
  output walk_state_e      state_q,
  output logic [LW-1:0]    lane_q
);
  walk_state_e   state_d;
  logic [LW-1:0] lane_d;
  logic          last_lane;

  assign last_lane = (lane_q == LW'(LANES - 1));

  always_comb begin
    state_d = state_q;
    lane_d  = lane_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SEEK;
          lane_d  = '0;
        end
      end
      ST_SEEK: begin
        if (mask_q[lane_q]) begin
          state_d = ST_WRITE;
        end else if (last_lane) begin
          state_d = ST_FIN;
        end else begin
          lane_d = lane_q + LW'(1);
        end
      end
      ST_WRITE: begin
        if (last_lane) begin
          state_d = ST_FIN;
        end else begin
          state_d = ST_SEEK;
          lane_d  = lane_q + LW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
    end
  end
endmodule

// File: rtl/fadd_lane_datapath.sv
module fadd_lane_datapath #(
  parameter int LANES = 8,
  parameter int AW    = 6,
  parameter int DW    = 32,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LW-1:0]       lane,
  input  logic [AW-1:0]       base,
  input  logic [LANES*AW-1:0] idx_vec,
  input  logic [LANES*DW-1:0] add_vec,
  input  logic [DW-1:0]       old_word,
  output logic [AW-1:0]       addr,
  output logic [DW-1:0]       sum
);
  logic [AW-1:0] lane_idx;
  logic [DW-1:0] lane_add;

  always_comb begin
    lane_idx = idx_vec[lane*AW +: AW];
    lane_add = add_vec[lane*DW +: DW];
    addr     = base + lane_idx;
    sum      = old_word + lane_add;
  end
endmodule

// File: rtl/fadd_return_buf.sv
module fadd_return_buf #(
  parameter int LANES = 8,
  parameter int DW    = 32,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                cap_en,
  input  logic [LW-1:0]       cap_lane,
  input  logic [DW-1:0]       cap_data,
  output logic [LANES*DW-1:0] held
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = cap_en && (cap_lane == LW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held[g*DW +: DW] <= '0;
      end else if (clear) begin
        held[g*DW +: DW] <= '0;
      end else if (hit) begin
        held[g*DW +: DW] <= cap_data;
      end
    end
  end
endmodule

// File: rtl/scatter_fadd_unit.sv
module scatter_fadd_unit
  import fadd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int RW    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic                op_return,
  input  logic [AW-1:0]       base_addr,
  input  logic [LANES*AW-1:0] index_vec,
  input  logic [LANES*DW-1:0] src_vec,
  input  logic [LANES-1:0]    lane_mask,
  input  logic [RW-1:0]       dest_reg,
  output logic                mem_rd_en,
  output logic [AW-1:0]       mem_rd_addr,
  input  logic [DW-1:0]       mem_rd_data,
  output logic                mem_wr_en,
  output logic [AW-1:0]       mem_wr_addr,
  output logic [DW-1:0]       mem_wr_data,
  output logic                busy,
  output logic                ret_valid,
  output logic [RW-1:0]       ret_dest,
  output logic [LANES-1:0]    ret_lane_we,
  output logic [LANES*DW-1:0] ret_data
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  walk_state_e         state_q;
  logic [LW-1:0]       lane_q;
  logic                start;
  logic [AW-1:0]       base_q;
  logic [LANES*AW-1:0] idx_q;
  logic [LANES*DW-1:0] add_q;
  logic [LANES-1:0]    mask_q;
  logic [RW-1:0]       dest_q;
  logic                want_ret_q;
  logic [AW-1:0]       lane_addr;
  logic [DW-1:0]       lane_sum;

  assign start = op_valid && (state_q == ST_IDLE);

  // operand capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      idx_q      <= '0;
      add_q      <= '0;
      mask_q     <= '0;
      dest_q     <= '0;
      want_ret_q <= 1'b0;
    end else if (start) begin
      base_q     <= base_addr;
      idx_q      <= index_vec;
      add_q      <= src_vec;
      mask_q     <= lane_mask;
      dest_q     <= dest_reg;
      want_ret_q <= op_return;
    end
  end

  fadd_lane_walker #(.LANES(LANES)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mask_q  (mask_q),
    .state_q (state_q),
    .lane_q  (lane_q)
  );

  fadd_lane_datapath #(.LANES(LANES), .AW(AW), .DW(DW)) u_path (
    .lane     (lane_q),
    .base     (base_q),
    .idx_vec  (idx_q),
    .add_vec  (add_q),
    .old_word (mem_rd_data),
    .addr     (lane_addr),
    .sum      (lane_sum)
  );

  fadd_return_buf #(.LANES(LANES), .DW(DW)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .cap_en   (state_q == ST_WRITE),
    .cap_lane (lane_q),
    .cap_data (mem_rd_data),
    .held     (ret_data)
  );

  assign mem_rd_en   = (state_q == ST_SEEK) && mask_q[lane_q];
  assign mem_rd_addr = lane_addr;
  assign mem_wr_en   = (state_q == ST_WRITE);
  assign mem_wr_addr = lane_addr;
  assign mem_wr_data = lane_sum;
  assign busy        = (state_q != ST_IDLE);
  assign ret_valid   = (state_q == ST_FIN) && want_ret_q;
  assign ret_dest    = dest_q;
  assign ret_lane_we = mask_q & {LANES{ret_valid}};
endmodule

// File: rtl/scatter_fadd_chk.sv
module scatter_fadd_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          busy,
  input logic          ret_valid,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_wr_addr
);
  // R12
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_wr_en && mem_wr_addr == $past(mem_rd_addr)));

  // R12
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R9
  ret_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (!ret_valid && !busy));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy) |=> busy);

  // R9
  ret_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> busy);
endmodule

bind scatter_fadd_unit scatter_fadd_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .busy        (busy),
  .ret_valid   (ret_valid),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr)
);

// File: tb/scatter_fadd_unit_bench.sv
module scatter_fadd_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int RW    = 6;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [RW-1:0]       dest;
    logic [LANES-1:0]    we;
    logic [LANES*DW-1:0] data;
  } exp_ret_t;

  logic                clk;
  logic                rst_n;
  logic                op_valid;
  logic                op_return;
  logic [AW-1:0]       base_addr;
  logic [LANES*AW-1:0] index_vec;
  logic [LANES*DW-1:0] src_vec;
  logic [LANES-1:0]    lane_mask;
  logic [RW-1:0]       dest_reg;
  logic                mem_rd_en;
  logic [AW-1:0]       mem_rd_addr;
  logic [DW-1:0]       mem_rd_data;
  logic                mem_wr_en;
  logic [AW-1:0]       mem_wr_addr;
  logic [DW-1:0]       mem_wr_data;
  logic                busy;
  logic                ret_valid;
  logic [RW-1:0]       ret_dest;
  logic [LANES-1:0]    ret_lane_we;
  logic [LANES*DW-1:0] ret_data;

  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  exp_ret_t      exp_q  [$];
  int            checks;
  int            fails;
  int            rd_cnt;
  bit            done;

  scatter_fadd_unit #(.LANES(LANES), .AW(AW), .DW(DW), .RW(RW)) u_scatter_fadd_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_return(op_return),
    .base_addr(base_addr), .index_vec(index_vec), .src_vec(src_vec),
    .lane_mask(lane_mask), .dest_reg(dest_reg),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .busy(busy), .ret_valid(ret_valid), .ret_dest(ret_dest),
    .ret_lane_we(ret_lane_we), .ret_data(ret_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // scratchpad model: one-cycle registered read
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr];
      rd_cnt      <= rd_cnt + 1;
    end
    if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected returns as the design produces them
  always @(negedge clk) begin
    if (rst_n && ret_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R10 unexpected return", 32'(ret_valid), 32'd0);
      end else begin
        exp_ret_t e;
        e = exp_q.pop_front();
        check(ret_dest == e.dest, "R5 dest", 32'(ret_dest), 32'(e.dest));
        check(ret_lane_we == e.we, "R6 lane we", 32'(ret_lane_we), 32'(e.we));
        for (int l = 0; l < LANES; l++)
          check(ret_data[l*DW +: DW] == e.data[l*DW +: DW], "R5/R7 lane data",
                ret_data[l*DW +: DW], e.data[l*DW +: DW]);
      end
    end
  end

  task automatic run_op(input bit ret, input logic [AW-1:0] base,
                        input logic [LANES*AW-1:0] idx, input logic [LANES*DW-1:0] src,
                        input logic [LANES-1:0] mask, input logic [RW-1:0] dest,
                        input bit poke);
    exp_ret_t e;
    int       mism;
    e.dest = dest;
    e.we   = mask;
    e.data = '0;
    for (int l = 0; l < LANES; l++) begin
      if (mask[l]) begin
        logic [AW-1:0] a;
        a = base + idx[l*AW +: AW];
        e.data[l*DW +: DW] = shadow[a];
        shadow[a] = shadow[a] + src[l*DW +: DW];
      end
    end
    if (ret) exp_q.push_back(e);
    @(negedge clk);
    rd_cnt    = 0;
    op_valid  = 1'b1;
    op_return = ret;
    base_addr = base;
    index_vec = idx;
    src_vec   = src;
    lane_mask = mask;
    dest_reg  = dest;
    @(negedge clk);
    op_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
    if (poke) begin
      // R10: request while busy, different operands
      op_valid  = 1'b1;
      op_return = 1'b1;
      base_addr = base + AW'(17);
      lane_mask = '1;
      @(negedge clk);
      op_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    check(rd_cnt == $countones(mask), "R6/R11 read count", 32'(rd_cnt),
          32'($countones(mask)));
    check(exp_q.size() == 0, "R8/R9 return count", 32'(exp_q.size()), 32'd0);
    mism = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== shadow[i]) mism++;
    check(mism == 0, "R3/R4/R7/R10 memory image", 32'(mism), 32'd0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LANES*AW-1:0] iv;
    logic [LANES*DW-1:0] sv;
    checks = 0; fails = 0; done = 0; rd_cnt = 0;
    op_valid = 0; op_return = 0; base_addr = '0; index_vec = '0;
    src_vec = '0; lane_mask = '0; dest_reg = '0;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = 32'h100 * i + 32'd7;
      shadow[i] = 32'h100 * i + 32'd7;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !ret_valid && !mem_rd_en && !mem_wr_en && ret_lane_we == '0,
          "R1 reset outputs", {busy, ret_valid, mem_rd_en, mem_wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !ret_valid, "R1 after release", {busy, ret_valid}, 32'd0);

    // R3/R4/R5: all lanes, distinct addresses
    for (int l = 0; l < LANES; l++) begin
      iv[l*AW +: AW] = AW'(l * 3);
      sv[l*DW +: DW] = 32'h11 * (l + 1);
    end
    run_op(1'b1, 6'd4, iv, sv, 8'hFF, 6'd9, 1'b0);

    // R6: partial mask
    run_op(1'b1, 6'd20, iv, sv, 8'b1010_0101, 6'd33, 1'b0);

    // R7: duplicate addresses on lanes 1, 3, 6
    for (int l = 0; l < LANES; l++) iv[l*AW +: AW] = AW'(l + 40);
    iv[1*AW +: AW] = 6'd2; iv[3*AW +: AW] = 6'd2; iv[6*AW +: AW] = 6'd2;
    run_op(1'b1, 6'd10, iv, sv, 8'hFF, 6'd63, 1'b0);

    // R3/R4: address and data wraparound
    for (int l = 0; l < LANES; l++) begin
      iv[l*AW +: AW] = AW'(l + 10);
      sv[l*DW +: DW] = 32'hFFFF_FFFF - 32'(l);
    end
    run_op(1'b1, 6'd60, iv, sv, 8'hFF, 6'd1, 1'b0);

    // R8: plain scatter-add
    run_op(1'b0, 6'd0, iv, sv, 8'b0111_1110, 6'd5, 1'b0);

    // R11: all lanes masked, returning and plain
    run_op(1'b1, 6'd8, iv, sv, 8'h00, 6'd12, 1'b0);
    run_op(1'b0, 6'd8, iv, sv, 8'h00, 6'd12, 1'b0);

    // R10: request during a walk is ignored
    run_op(1'b1, 6'd30, iv, sv, 8'b1100_0011, 6'd21, 1'b1);

    // back-to-back plain then return to the same addresses (R7)
    run_op(1'b0, 6'd2, iv, sv, 8'hFF, 6'd0, 1'b0);
    run_op(1'b1, 6'd2, iv, sv, 8'hFF, 6'd7, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule